// File: doc/BRIEF.md
# Output Driver Impedance Calibration Stepper

This block keeps track of the best strength code for an output driver while supply voltage and temperature drift. An external sense circuit compares the driver against its reference and reports one of three results each cycle: stronger, weaker or hold. The block samples that result at a fixed evaluation interval. At each evaluation it moves an internal working code by at most one level, and the code stops at either end of its range instead of wrapping.

The driver itself only receives a new code while the outputs float. Write and deselect cycles put the outputs in high impedance, which gives the block a safe moment to apply the code. During stretches with no such window, the applied code stays frozen and the working code keeps following the comparator. After a settling period counted from reset, the first move of the outputs from driving to floating marks the code as calibrated. The flag then stays set until the next reset.

Top module: `drv_cal_stepper`

## Requirements
- R1: An evaluation takes place once every `EVAL_PERIOD` cycles. The first one happens on the `EVAL_PERIOD`-th rising edge after reset is released, so with `out_hiz` high the applied code first changes on edge `EVAL_PERIOD`+1.
- R2: Each evaluation changes the working code by at most one level. On `cmp_dir` the value 2'b01 means one level up, 2'b10 means one level down, and 2'b00 and 2'b11 both mean hold. Between evaluations the working code does not change.
- R3: The working code saturates at 0 and at 2^`CODE_W`-1 and never wraps.
- R4: With default parameters the applied code `drv_code` is 5 bits wide, which gives 32 strength levels.
- R5: `drv_code` changes only on a rising edge at which `out_hiz` is high. On that edge it takes the current working code.
- R6: While `out_hiz` stays low, `drv_code` keeps its last value and the working code goes on tracking. The first edge with `out_hiz` high then applies the tracked value.
- R7: `calibrated` rises after the first rising edge at which `out_hiz` is high, `out_hiz` was low on the previous edge, and at least `SETTLE_CYCLES` edges have passed since reset. Once set, it stays set until reset.
- R8: During reset, `drv_code` equals `RESET_CODE` (16 by default) and `calibrated` is 0.
- R9: A driving-to-floating transition before the settling period ends does not set `calibrated`. Neither does holding `out_hiz` high continuously from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_dir | input | 2 | Comparator result: 01 up, 10 down, 00/11 hold |
| out_hiz | input | 1 | High when the outputs are in high impedance |
| drv_code | output | CODE_W | Strength code applied to the driver |
| calibrated | output | 1 | Set once the code is considered converged |

## Verification
The bench builds the block with `EVAL_PERIOD` = 8 and `SETTLE_CYCLES` = 40, and keeps the 5-bit code width and the mid-scale reset code. The short interval lets both saturation limits be reached from mid-scale within a few hundred cycles. It also makes the exact edge of the first and second evaluations easy to count. The short settling period lets a single run place one driving-to-floating transition before the settling point and one after it.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
   typedef enum logic [1:0] {
      DIR_HOLD  = 2'b00,
      DIR_UP    = 2'b01,
      DIR_DOWN  = 2'b10,
      DIR_HOLD2 = 2'b11
   } cal_dir_e;
endpackage

// File: rtl/cal_tick_gen.sv
`timescale 1ns/1ps
module cal_tick_gen #(
   parameter int PERIOD = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int  CW   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam bit  POW2 = ((PERIOD & (PERIOD - 1)) == 0);

   logic [CW-1:0] cnt_q;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("cal_tick_gen: PERIOD must be at least 2");
      end
      if (POW2) begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick = &cnt_q;
      end else begin : g_cmp
         localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);
      end
   endgenerate

   // R1: evaluations are never back to back
   assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/cal_code_tracker.sv
`timescale 1ns/1ps
module cal_code_tracker
   import cal_pkg::*;
#(
   parameter int CODE_W     = 5,
   parameter int RESET_CODE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  cal_dir_e          dir,
   output logic [CODE_W-1:0] work
);
   localparam logic [CODE_W-1:0] MAXC = '1;
   localparam logic [CODE_W-1:0] MINC = '0;
   localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

   logic [CODE_W-1:0] work_d;

   always_comb begin
      work_d = work;
      if (tick) begin
         unique case (dir)
            DIR_UP:   if (work != MAXC) work_d = work + 1'b1;
            DIR_DOWN: if (work != MINC) work_d = work - 1'b1;
            default:  work_d = work;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) work <= INIT;
      else        work <= work_d;
   end

   assert_quiet_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(work));
   assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (work == $past(work)) || (work == $past(work) + 1'b1)
               || (work == $past(work) - 1'b1));
   assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (work == MAXC) |=> (work != MINC));
   assert_no_wrap_bottom_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (work == MINC) |=> (work != MAXC));
endmodule

// File: rtl/cal_apply_gate.sv
`timescale 1ns/1ps
module cal_apply_gate #(
   parameter int CODE_W     = 5,
   parameter int RESET_CODE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_hiz,
   input  logic [CODE_W-1:0] work,
   output logic [CODE_W-1:0] applied
);
   always_ff @(posedge clk) begin
      if (!rst_n)       applied <= CODE_W'(RESET_CODE);
      else if (out_hiz) applied <= work;
   end

   assert_frozen_when_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_hiz |=> $stable(applied));
   assert_follows_in_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_hiz |=> (applied == $past(work)));
endmodule

// File: rtl/cal_lock_detect.sv
`timescale 1ns/1ps
module cal_lock_detect #(
   parameter int SETTLE_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic out_hiz,
   output logic calibrated
);
   localparam int SW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_CYCLES);

   logic [SW-1:0] settle_q;
   logic          hiz_prev_q;
   logic          settled;

   assign settled = (settle_q == SETTLE_END);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settle_q   <= '0;
         hiz_prev_q <= 1'b1;
         calibrated <= 1'b0;
      end else begin
         if (!settled) settle_q <= settle_q + 1'b1;
         hiz_prev_q <= out_hiz;
         if (settled && out_hiz && !hiz_prev_q) calibrated <= 1'b1;
      end
   end

   assert_flag_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      calibrated |-> settled);
   assert_flag_on_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(calibrated) |-> $past(out_hiz));
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      calibrated |=> calibrated);
endmodule

// File: rtl/drv_cal_stepper.sv
`timescale 1ns/1ps
module drv_cal_stepper
   import cal_pkg::*;
#(
   parameter int CODE_W        = 5,
   parameter int EVAL_PERIOD   = 64,
   parameter int SETTLE_CYCLES = 4096,
   parameter int RESET_CODE    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmp_dir,
   input  logic              out_hiz,
   output logic [CODE_W-1:0] drv_code,
   output logic              calibrated
);
   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("drv_cal_stepper: CODE_W must be at least 2");
      end
      if (RESET_CODE < 0 || RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
         $error("drv_cal_stepper: RESET_CODE outside code range");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("drv_cal_stepper: SETTLE_CYCLES must be positive");
      end
   endgenerate

   logic              eval_tick;
   logic [CODE_W-1:0] work_code;

   cal_tick_gen #(.PERIOD(EVAL_PERIOD)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (eval_tick)
   );

   cal_code_tracker #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (eval_tick),
      .dir  (cal_dir_e'(cmp_dir)),
      .work (work_code)
   );

   cal_apply_gate #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .out_hiz(out_hiz),
      .work   (work_code),
      .applied(drv_code)
   );

   cal_lock_detect #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_hiz   (out_hiz),
      .calibrated(calibrated)
   );

   assert_reset_state_R8: assert property (@(posedge clk)
      !rst_n |=> (drv_code == CODE_W'(RESET_CODE)) && !calibrated);
endmodule

// File: tb/drv_cal_stepper_tb.sv
`timescale 1ns/1ps
module drv_cal_stepper_tb;
   localparam int W = 5;
   localparam int P = 8;
   localparam int S = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cmp_dir = 2'b00;
   logic         out_hiz = 1'b1;
   logic [W-1:0] drv_code;
   logic         calibrated;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   drv_cal_stepper #(.CODE_W(W), .EVAL_PERIOD(P), .SETTLE_CYCLES(S), .RESET_CODE(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_dir(cmp_dir), .out_hiz(out_hiz),
      .drv_code(drv_code), .calibrated(calibrated)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic hiz, input logic [1:0] dir);
      @(negedge clk);
      rst_n = 1'b0; out_hiz = hiz; cmp_dir = dir;
      step(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      @(negedge clk); rst_n = 1'b0; step(2);
      check("R8 code in reset", drv_code, 16);
      check("R8 flag in reset", calibrated, 0);
      check("R4 code width", $bits(drv_code), 5);
   endtask

   task automatic t_interval_and_saturate_up();
      do_reset(1'b1, 2'b01);
      step(P);       check("R1 before first evaluation", drv_code, 16);
      step(1);       check("R1 first evaluation", drv_code, 17);
      step(P - 1);   check("R2 single step held", drv_code, 17);
      step(1);       check("R2 second evaluation", drv_code, 18);
      step(200);     check("R3 saturate top", drv_code, 31);
      step(3 * P);   check("R3 no wrap at top", drv_code, 31);
   endtask

   task automatic t_saturate_down();
      do_reset(1'b1, 2'b10);
      step(P + 1);   check("R2 down step", drv_code, 15);
      step(200);     check("R3 saturate bottom", drv_code, 0);
      step(3 * P);   check("R3 no wrap at bottom", drv_code, 0);
   endtask

   task automatic t_hold_codes();
      do_reset(1'b1, 2'b00);
      step(5 * P);   check("R2 hold 00", drv_code, 16);
      cmp_dir = 2'b11;
      step(5 * P);   check("R2 hold 11", drv_code, 16);
   endtask

   task automatic t_gate_while_driving();
      do_reset(1'b0, 2'b01);
      step(3 * P + 4);
      check("R5 frozen while driving", drv_code, 16);
      cmp_dir = 2'b00; out_hiz = 1'b1;
      step(1);
      check("R6 tracked value applied", drv_code, 19);
   endtask

   task automatic t_lock();
      do_reset(1'b0, 2'b00);
      step(10); out_hiz = 1'b1; step(1);
      check("R9 early float ignored", calibrated, 0);
      out_hiz = 1'b0; step(S + 10);
      check("R7 no flag without float", calibrated, 0);
      out_hiz = 1'b1; step(1);
      check("R7 flag on float after settle", calibrated, 1);
      out_hiz = 1'b0; step(5);
      check("R7 flag sticky", calibrated, 1);
      do_reset(1'b1, 2'b00);
      step(S + 20);
      check("R9 constant float sets nothing", calibrated, 0);
   endtask

   initial begin
      t_reset_state();
      t_interval_and_saturate_up();
      t_saturate_down();
      t_hold_codes();
      t_gate_while_driving();
      t_lock();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule